// File: doc/BRIEF.md
# Dual-Mode Serial Register Access Port

This block is the slave side of a serial link into a 256-address register and RAM map. Each transaction begins when chip enable rises. The first byte is an address, and its top bit chooses write or read. Any number of data bytes may follow. After each data byte the address pointer steps forward. It wraps inside one window for the clock registers and inside another for the user RAM. The writing and reading directions use different halves of the address space, so each direction has its own wrap points.

A mode input selects between two link types:
- **SPI mode** has separate data-in and data-out lines and shifts bytes most significant bit first. It accepts either idle level of the serial clock, because it samples that level when chip enable rises.
- **3-wire mode** shares one data line and shifts bytes least significant bit first. The bench models the shared line as `sdi_in` tied to `sdo_out` whenever `sdo_oe` is high.

All serial inputs are brought into the system clock domain, and their edges are detected there. The serial clock never clocks any logic directly.

The port copies the time bytes when a read address arrives. Every byte of that burst then comes from the copy, while the live counters keep running. The port also keeps a write-protect flag and applies it to all writes. Data stores are not part of this block. The port gives the map a read address and expects the data one system clock later. It sends the map a single-cycle write strobe with an address and a data byte.

Top module: `serial_regport`

## Requirements
- R1: The first byte after chip enable rises is the address. Address bit 7 = 1 makes the transfer a write and bit 7 = 0 makes it a read. A read never produces a write strobe.
- R2: In SPI mode (`mode_spi`=1) bytes are shifted MSB first. In 3-wire mode (`mode_spi`=0) they are shifted LSB first, in both directions.
- R3: In SPI mode the idle level of `sck_in` is sampled at chip-enable rise. Input bits are taken on the edge that returns to that level, and output bits change on the edge that leaves it. In 3-wire mode input is taken on the rising edge and output changes on the falling edge.
- R4: The pointer advances after every data byte. Its low 7 bits go from 1Fh to 00h and from 7Fh to 20h, so writes cycle 80h–9Fh or A0h–FFh and reads cycle 00h–1Fh or 20h–7Fh.
- R5: `sdo_oe` stays 0 until the first read data byte is loaded. It is never 1 during a write, and it returns to 0 once chip enable falls.
- R6: A write-protect flag is held in bit 6 of the control register (low address 0Fh). It is 1 after reset.
  - While the flag is 1, no write strobe is issued, including for a write to 8Fh.
  - A write to 8Fh while the flag is 1 only updates the flag from bit 6 of the data.
  - While the flag is 0, a write to 8Fh is passed on and also updates the flag.
- R7: Reads of 12h–1Fh return 00h. Writes to 92h–9Fh produce no strobe, but the pointer still advances.
- R8: A write byte whose eighth bit has not arrived when chip enable falls produces no strobe.
- R9: Reads of 00h–06h return a copy of `time_in` (byte n at bits 8n+7:8n), taken when the read address byte completes.
- R10: Each accepted write byte gives exactly one single-cycle `wr_en` pulse, with `wr_addr` set to the low 7 bits of the pointer.
- R11: After reset `sdo_oe` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_spi | input | 1 | 1 = SPI, 0 = 3-wire |
| cs_in | input | 1 | Chip enable, active high |
| sck_in | input | 1 | Serial clock from master |
| sdi_in | input | 1 | Serial data in (shared line in 3-wire mode) |
| sdo_out | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo_out |
| rd_addr | output | 7 | Map read address |
| rd_data | input | 8 | Map read data, valid one clock after rd_addr |
| time_in | input | 56 | Live time bytes 00h–06h |
| wr_en | output | 1 | Map write strobe |
| wr_addr | output | 7 | Map write address |
| wr_data | output | 8 | Map write data |

## Verification
The assertions check these properties on every clock:
- the output enable drops after deselect and stays low through write transfers;
- the write strobe is always a single pulse;
- no strobe ever reaches the reserved window;
- no strobe follows a cycle with write protect set;
- a strobe only ever comes from the write phase.

Other behaviour can only be shown by the bench scenarios, because it depends on values carried across whole transfers:
- bit order in each mode;
- both SPI clock polarities;
- the wrap points in each window;
- the snapshot staying frozen while `time_in` changes;
- the write-protect sequence;
- discarding a truncated byte.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  // Advance a pointer, wrapping inside the clock or RAM window; bit 7 is kept.
  function automatic logic [7:0] step_ptr(
    input logic [7:0] p,
    input logic [6:0] clk_top,
    input logic [6:0] ram_base,
    input logic [6:0] ram_top
  );
    logic [6:0] low;
    low = p[6:0];
    if (low == clk_top)      low = 7'h00;
    else if (low == ram_top) low = ram_base;
    else                     low = low + 7'd1;
    return {p[7], low};
  endfunction

endpackage

// File: rtl/serial_regport_sync.sv
module serial_regport_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/serial_regport_ptr.sv
module serial_regport_ptr
  import serial_regport_pkg::*;
#(
  parameter logic [6:0] CLK_TOP  = 7'h1F,
  parameter logic [6:0] RAM_BASE = 7'h20,
  parameter logic [6:0] RAM_TOP  = 7'h7F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  output logic [7:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= step_ptr(ptr, CLK_TOP, RAM_BASE, RAM_TOP);
  end
endmodule

// File: rtl/serial_regport_wgate.sv
module serial_regport_wgate #(
  parameter logic [6:0]  RSV_LO   = 7'h12,
  parameter logic [6:0]  CLK_TOP  = 7'h1F,
  parameter logic [6:0]  CTL_ADDR = 7'h0F,
  parameter int unsigned WP_BIT   = 6,
  parameter logic        WP_INIT  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [7:0] addr,
  input  logic [7:0] data,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data
);
  logic wp_q;
  logic in_rsv;
  logic is_ctl;

  assign in_rsv = (addr[6:0] >= RSV_LO) && (addr[6:0] <= CLK_TOP);
  assign is_ctl = (addr[6:0] == CTL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= WP_INIT;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (req && !in_rsv) begin
        wr_addr <= addr[6:0];
        wr_data <= data;
        if (!wp_q) wr_en <= 1'b1;
        if (is_ctl) wp_q <= data[WP_BIT];
      end
    end
  end
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import serial_regport_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIME_BYTES  = 7,
  parameter logic [6:0]  CLK_TOP     = 7'h1F,
  parameter logic [6:0]  RSV_LO      = 7'h12,
  parameter logic [6:0]  RAM_BASE    = 7'h20,
  parameter logic [6:0]  RAM_TOP     = 7'h7F,
  parameter logic [6:0]  CTL_ADDR    = 7'h0F,
  parameter int unsigned WP_BIT      = 6,
  parameter logic        WP_INIT     = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode_spi,
  input  logic                      cs_in,
  input  logic                      sck_in,
  input  logic                      sdi_in,
  output logic                      sdo_out,
  output logic                      sdo_oe,
  output logic [6:0]                rd_addr,
  input  logic [7:0]                rd_data,
  input  logic [TIME_BYTES*8-1:0]   time_in,
  output logic                      wr_en,
  output logic [6:0]                wr_addr,
  output logic [7:0]                wr_data
);
  localparam int unsigned SNAP_W = TIME_BYTES * 8;
  localparam logic [2:0]  LAST_BIT = 3'd7;

  logic [2:0] sync_out;
  logic cs_s, sck_s, sdi_s;
  logic cs_q, sck_q;
  logic cs_rise, sck_rise, sck_fall;
  logic cpol_q;
  logic samp_ev, drv_ev;
  logic [7:0] rx_q, rx_next, tx_q, byte_sel, snap_byte;
  logic [2:0] cnt_q;
  phase_t phase;
  logic byte_done, addr_done;
  logic [7:0] ptr;
  logic [SNAP_W-1:0] snap_q;

  serial_regport_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_in({cs_in, sck_in, sdi_in}),
    .d_out(sync_out)
  );
  assign {cs_s, sck_s, sdi_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign cs_rise  = cs_s && !cs_q;
  assign sck_rise = sck_s && !sck_q;
  assign sck_fall = !sck_s && sck_q;

  // Sample on the edge back to idle (SPI) or rising (3-wire); drive on the other.
  always_comb begin
    samp_ev = 1'b0;
    drv_ev  = 1'b0;
    if (cs_s && !cs_rise) begin
      if (mode_spi) begin
        samp_ev = cpol_q ? sck_rise : sck_fall;
        drv_ev  = cpol_q ? sck_fall : sck_rise;
      end else begin
        samp_ev = sck_rise;
        drv_ev  = sck_fall;
      end
    end
  end

  assign rx_next   = mode_spi ? {rx_q[6:0], sdi_s} : {sdi_s, rx_q[7:1]};
  assign byte_done = samp_ev && (cnt_q == LAST_BIT);
  assign addr_done = byte_done && (phase == PH_ADDR);

  serial_regport_ptr #(
    .CLK_TOP(CLK_TOP), .RAM_BASE(RAM_BASE), .RAM_TOP(RAM_TOP)
  ) u_ptr (
    .clk(clk), .rst(rst),
    .load(addr_done), .load_val(rx_next),
    .step(byte_done && (phase != PH_ADDR)),
    .ptr(ptr)
  );

  serial_regport_wgate #(
    .RSV_LO(RSV_LO), .CLK_TOP(CLK_TOP), .CTL_ADDR(CTL_ADDR),
    .WP_BIT(WP_BIT), .WP_INIT(WP_INIT)
  ) u_wgate (
    .clk(clk), .rst(rst),
    .req(byte_done && (phase == PH_WRITE)),
    .addr(ptr), .data(rx_next),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rd_addr = ptr[6:0];

  // Snapshot of the time bytes, captured when a read address completes.
  always_ff @(posedge clk) begin
    if (addr_done && !rx_next[7]) snap_q <= time_in;
  end

  always_comb begin
    snap_byte = '0;
    for (int i = 0; i < TIME_BYTES; i++) begin
      if (ptr[6:0] == 7'(i)) snap_byte = snap_q[i*8 +: 8];
    end
  end

  always_comb begin
    if (ptr[6:0] < 7'(TIME_BYTES))                       byte_sel = snap_byte;
    else if (ptr[6:0] >= RSV_LO && ptr[6:0] <= CLK_TOP) byte_sel = '0;
    else                                                 byte_sel = rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ADDR;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      cpol_q  <= 1'b0;
      sdo_out <= 1'b0;
      sdo_oe  <= 1'b0;
    end else if (!cs_s) begin
      phase  <= PH_ADDR;
      cnt_q  <= '0;
      sdo_oe <= 1'b0;
    end else if (cs_rise) begin
      cpol_q <= sck_s;
      phase  <= PH_ADDR;
      cnt_q  <= '0;
    end else begin
      if (samp_ev) begin
        rx_q  <= rx_next;
        cnt_q <= cnt_q + 3'd1;
        if (addr_done) phase <= rx_next[7] ? PH_WRITE : PH_READ;
      end
      if (drv_ev && phase == PH_READ) begin
        if (cnt_q == 3'd0) begin
          tx_q    <= byte_sel;
          sdo_out <= mode_spi ? byte_sel[7] : byte_sel[0];
          sdo_oe  <= 1'b1;
        end else if (mode_spi) begin
          tx_q    <= {tx_q[6:0], 1'b0};
          sdo_out <= tx_q[6];
        end else begin
          tx_q    <= {1'b0, tx_q[7:1]};
          sdo_out <= tx_q[1];
        end
      end
    end
  end
endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk
  import serial_regport_pkg::*;
#(
  parameter logic [6:0] RSV_LO  = 7'h12,
  parameter logic [6:0] CLK_TOP = 7'h1F
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input phase_t     phase,
  input logic       sdo_oe,
  input logic       wr_en,
  input logic [6:0] wr_addr,
  input logic       wp
);
  p_oe_release_r5: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !sdo_oe);

  p_oe_quiet_write_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE) |-> !sdo_oe);

  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(wp));

  p_rsv_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !(wr_addr >= RSV_LO && wr_addr <= CLK_TOP));

  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_strobe_from_write_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(phase) == PH_WRITE));
endmodule

bind serial_regport serial_regport_chk #(.RSV_LO(RSV_LO), .CLK_TOP(CLK_TOP)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .phase(phase), .sdo_oe(sdo_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wp(u_wgate.wp_q)
);

// File: tb/test_serial_regport.sv
module test_serial_regport;
  localparam int H = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, mode_spi, cs_in, sck_in, tb_sdi;
  logic sdo_out, sdo_oe, wr_en;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [55:0] time_in;
  wire sdi_in = (!mode_spi && sdo_oe) ? sdo_out : tb_sdi;

  serial_regport i_serial_regport (
    .clk(clk), .rst(rst), .mode_spi(mode_spi), .cs_in(cs_in), .sck_in(sck_in),
    .sdi_in(sdi_in), .sdo_out(sdo_out), .sdo_oe(sdo_oe), .rd_addr(rd_addr),
    .rd_data(rd_data), .time_in(time_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  logic [7:0] bmem [0:127];
  int n_chk = 0, n_err = 0, n_wr = 0;
  logic oe_seen = 1'b0;
  logic cpol_tb = 1'b0;

  always @(posedge clk) begin
    if (wr_en) bmem[wr_addr] <= wr_data;
    rd_data <= bmem[rd_addr];
    if (!rst && wr_en) n_wr <= n_wr + 1;
    if (sdo_oe) oe_seen <= 1'b1;
  end

  function automatic logic [7:0] orig(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic begin_xfer(input logic spi, input logic cpol);
    mode_spi = spi;
    cpol_tb  = cpol;
    sck_in   = spi ? cpol : 1'b0;
    wait_h();
    cs_in = 1'b1;
    wait_h();
  endtask

  task automatic end_xfer();
    wait_h();
    cs_in = 1'b0;
    wait_h();
    wait_h();
  endtask

  task automatic bit_io(input logic din, output logic dout);
    if (mode_spi) begin
      sck_in = ~cpol_tb;
      tb_sdi = din;
      wait_h();
      dout = sdo_out;
      sck_in = cpol_tb;
      wait_h();
    end else begin
      tb_sdi = din;
      wait_h();
      dout = sdi_in;
      sck_in = 1'b1;
      wait_h();
      sck_in = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] din, output logic [7:0] dout);
    for (int i = 0; i < 8; i++) begin
      int idx;
      logic b;
      idx = mode_spi ? 7 - i : i;
      bit_io(din[idx], b);
      dout[idx] = b;
    end
  endtask

  task automatic wr1(input logic spi, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] junk;
    begin_xfer(spi, 1'b0);
    xbyte(a, junk);
    xbyte(d, junk);
    end_xfer();
  endtask

  task automatic t_reset();
    check("R11 oe after reset", {7'd0, sdo_oe}, 8'h00);
    check("R11 wr_en after reset", {7'd0, wr_en}, 8'h00);
  endtask

  task automatic t_write_protect();
    int n0;
    n0 = n_wr;
    wr1(1'b1, 8'h81, 8'h33);
    check("R6 write blocked at reset", bmem[1], orig(1));
    check("R6 no strobe while protected", 8'(n_wr - n0), 8'h00);
    wr1(1'b1, 8'h8F, 8'h07);
    check("R6 clearing write leaves ctl", bmem[8'h0F], orig(8'h0F));
    wr1(1'b1, 8'h8F, 8'h05);
    check("R6 ctl written when clear", bmem[8'h0F], 8'h05);
    wr1(1'b1, 8'h8F, 8'h45);
    check("R6 ctl written setting wp", bmem[8'h0F], 8'h45);
    wr1(1'b0, 8'h81, 8'h33);
    check("R6 blocked after set", bmem[1], orig(1));
    wr1(1'b1, 8'h8F, 8'h00);
    check("R6 clear only touches flag", bmem[8'h0F], 8'h45);
    wr1(1'b1, 8'h81, 8'h33);
    check("R6 write after clear", bmem[1], 8'h33);
  endtask

  task automatic t_clk_burst_write();
    logic [7:0] junk;
    int n0;
    n0 = n_wr;
    oe_seen = 1'b0;
    begin_xfer(1'b1, 1'b1);
    xbyte(8'h9E, junk);
    xbyte(8'hAA, junk);
    xbyte(8'hBB, junk);
    xbyte(8'hCC, junk);
    xbyte(8'hDD, junk);
    end_xfer();
    check("R7 reserved 1E not written", bmem[8'h1E], orig(8'h1E));
    check("R7 reserved 1F not written", bmem[8'h1F], orig(8'h1F));
    check("R4 clock write wraps to 80", bmem[0], 8'hCC);
    check("R4 clock write continues 81", bmem[1], 8'hDD);
    check("R10 one strobe per accepted byte", 8'(n_wr - n0), 8'd2);
    check("R5 oe never during write", {7'd0, oe_seen}, 8'h00);
  endtask

  task automatic t_ram_write_3w();
    logic [7:0] junk;
    begin_xfer(1'b0, 1'b0);
    xbyte(8'hFE, junk);
    xbyte(8'h11, junk);
    xbyte(8'hC1, junk);
    xbyte(8'h22, junk);
    end_xfer();
    check("R2 3-wire LSB-first write 7E", bmem[8'h7E], 8'h11);
    check("R4 ram write 7F", bmem[8'h7F], 8'hC1);
    check("R4 ram write wraps to A0", bmem[8'h20], 8'h22);
  endtask

  task automatic t_spi_read(input logic cpol);
    logic [7:0] d0, d1, d2, junk;
    int n0;
    n0 = n_wr;
    begin_xfer(1'b1, cpol);
    xbyte(8'h7E, junk);
    check("R5 oe low before first byte", {7'd0, sdo_oe}, 8'h00);
    xbyte(8'h00, d0);
    xbyte(8'h00, d1);
    xbyte(8'h00, d2);
    check("R5 oe high while reading", {7'd0, sdo_oe}, 8'h01);
    end_xfer();
    check("R3 R2 spi read 7E", d0, 8'h11);
    check("R3 spi read 7F", d1, 8'hC1);
    check("R4 ram read wraps to 20", d2, 8'h22);
    check("R5 oe released after CE", {7'd0, sdo_oe}, 8'h00);
    check("R1 read gives no strobe", 8'(n_wr - n0), 8'h00);
  endtask

  task automatic t_snapshot_3w();
    logic [7:0] d0, d1, d2, junk;
    time_in = 56'h66_55_44_33_22_11_10;
    begin_xfer(1'b0, 1'b0);
    xbyte(8'h1F, junk);
    time_in = 56'hE6_E5_E4_E3_E2_E1_E0;
    xbyte(8'h00, d0);
    xbyte(8'h00, d1);
    xbyte(8'h00, d2);
    end_xfer();
    check("R7 reserved read 1F is zero", d0, 8'h00);
    check("R9 R4 snapshot byte 0 after wrap", d1, 8'h10);
    check("R9 snapshot byte 1 frozen", d2, 8'h11);
    begin_xfer(1'b0, 1'b0);
    xbyte(8'h06, junk);
    xbyte(8'h00, d0);
    end_xfer();
    check("R9 new read takes fresh copy", d0, 8'hE6);
    begin_xfer(1'b1, 1'b0);
    xbyte(8'h11, junk);
    xbyte(8'h00, d0);
    xbyte(8'h00, d1);
    end_xfer();
    check("R7 map read 11", d0, orig(8'h11));
    check("R7 reserved read 12 is zero", d1, 8'h00);
  endtask

  task automatic t_partial_write();
    logic [7:0] junk;
    logic b;
    int n0;
    n0 = n_wr;
    begin_xfer(1'b0, 1'b0);
    xbyte(8'hA5, junk);
    for (int i = 0; i < 5; i++) bit_io(1'b1, b);
    end_xfer();
    check("R8 truncated byte no strobe", 8'(n_wr - n0), 8'h00);
    check("R8 truncated byte not stored", bmem[8'h25], orig(8'h25));
    wr1(1'b0, 8'hA5, 8'h3C);
    check("R8 full byte after truncation", bmem[8'h25], 8'h3C);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) bmem[i] = orig(i);
    rst = 1'b1; mode_spi = 1'b1; cs_in = 1'b0; sck_in = 1'b0; tb_sdi = 1'b0;
    time_in = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_protect();
    t_clk_burst_write();
    t_ram_write_3w();
    t_spi_read(1'b1);
    t_spi_read(1'b0);
    t_snapshot_3w();
    t_partial_write();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule